// File: doc/BRIEF.md
# In-Order Pipeline Hazard Controller

This block sequences instructions through a short in-order processor pipeline. It does not model the datapath. It takes one instruction descriptor per cycle over a valid/ready handshake. Each descriptor carries an instruction class, a tag, a destination register, two source registers with use flags, and an execute-cycle count. The block moves each instruction through its stages and decides when a stage must hold.

Register-to-register and multi-cycle arithmetic instructions go from execute straight to write-back. Loads and stores pass through two memory stages before write-back. An independent register instruction issued after a load can therefore write back before that load does. A pending bit for each register guards decode against outstanding loads. Separate integer and memory write-back ports let both paths complete in the same cycle.

Every cycle the block reports the valid bit and tag of each stage, together with a strobe, register number and tag for each write-back port. The surrounding core uses these outputs to drive its datapath.

Top module: `inorder_hazard_ctl`

## Requirements
- R1: With no stall, the block accepts one descriptor in every cycle. An integer instruction (class 0) accepted in cycle c spends one cycle in each of fetch, decode and execute, and shows a `wbi_we` strobe carrying its tag in cycle c+4.
- R2: A load (class 1) accepted in cycle c, with `mem_rdy` high, is in memory-1 in cycle c+4 and memory-2 in cycle c+5. It shows `wbm_we` with its destination register and tag in cycle c+6.
- R3: While `mem_rdy` is low, the instruction in memory-1 stays there with the same tag. It moves to memory-2 in the cycle after a cycle in which `mem_rdy` is high.
- R4: An integer instruction with no register dependency on an earlier load writes back on the integer port before that load writes back.
- R5: A multi-cycle instruction (class 3) with count N stays in execute for N cycles (a count of 0 behaves as 1) and writes back on the integer port. The instruction behind it waits in decode and writes back one cycle later.
- R6: A load's destination register is pending from the load's exit from decode until its write-back. An instruction whose used source (`in_srcuse` bit 0 for `in_src0`, bit 1 for `in_src1`), or whose destination (all classes except store), is pending stays in decode. It writes back on the integer port three cycles after the load's write-back cycle.
- R7: An integer write-back and a memory write-back in the same cycle are both reported, each on its own port.
- R8: A store (class 2) takes the load's stage sequence and raises `wbm_v` with `wbm_we` low. It never marks a register pending, so a following reader of its destination register does not stall.
- R9: While decode holds an instruction that cannot advance, `in_ready` is low, and the instructions in fetch and decode keep their tags.
- R10: Synchronous active-high reset empties every stage, clears all pending bits and raises `in_ready`. An instruction that was in flight never writes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted this cycle when valid |
| in_class | input | 2 | 0 integer, 1 load, 2 store, 3 multi-cycle |
| in_tag | input | TAG_W | Instruction tag |
| in_dst | input | RW | Destination register |
| in_src0 | input | RW | First source register |
| in_src1 | input | RW | Second source register |
| in_srcuse | input | 2 | Source use flags (bit 0 src0, bit 1 src1) |
| in_cnt | input | CNT_W | Execute cycles for class 3 |
| mem_rdy | input | 1 | Memory accepts the access in memory-1 |
| fe_v | output | 1 | Fetch stage occupied |
| fe_tag | output | TAG_W | Fetch stage tag |
| de_v | output | 1 | Decode stage occupied |
| de_tag | output | TAG_W | Decode stage tag |
| ex_v | output | 1 | Execute stage occupied |
| ex_tag | output | TAG_W | Execute stage tag |
| m1_v | output | 1 | Memory-1 stage occupied |
| m1_tag | output | TAG_W | Memory-1 stage tag |
| m2_v | output | 1 | Memory-2 stage occupied |
| m2_tag | output | TAG_W | Memory-2 stage tag |
| wbi_we | output | 1 | Integer-port write strobe |
| wbi_reg | output | RW | Integer-port register |
| wbi_tag | output | TAG_W | Integer-port tag |
| wbm_v | output | 1 | Memory write-back slot occupied |
| wbm_we | output | 1 | Memory-port write strobe (loads only) |
| wbm_reg | output | RW | Memory-port register |
| wbm_tag | output | TAG_W | Memory-port tag |

## Verification
Two events can land in the same cycle: the integer port's write-back of a register instruction and the memory port's write-back of an earlier load. The bench accepts a load, waits one idle cycle, and then issues an independent integer instruction. The two timelines then meet in one cycle. The check requires both strobes, with the right tags, in exactly that cycle.

// File: rtl/inorder_hazard_ctl.sv
module inorder_hazard_ctl #(
  parameter int NREG  = 16,
  parameter int TAG_W = 4,
  parameter int CNT_W = 4,
  localparam int RW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_class,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [RW-1:0]    in_dst,
  input  logic [RW-1:0]    in_src0,
  input  logic [RW-1:0]    in_src1,
  input  logic [1:0]       in_srcuse,
  input  logic [CNT_W-1:0] in_cnt,
  input  logic             mem_rdy,
  output logic             fe_v,
  output logic [TAG_W-1:0] fe_tag,
  output logic             de_v,
  output logic [TAG_W-1:0] de_tag,
  output logic             ex_v,
  output logic [TAG_W-1:0] ex_tag,
  output logic             m1_v,
  output logic [TAG_W-1:0] m1_tag,
  output logic             m2_v,
  output logic [TAG_W-1:0] m2_tag,
  output logic             wbi_we,
  output logic [RW-1:0]    wbi_reg,
  output logic [TAG_W-1:0] wbi_tag,
  output logic             wbm_v,
  output logic             wbm_we,
  output logic [RW-1:0]    wbm_reg,
  output logic [TAG_W-1:0] wbm_tag
);

  localparam logic [1:0] C_INT = 2'd0, C_LD = 2'd1, C_ST = 2'd2, C_MUL = 2'd3;

  typedef struct packed {
    logic [1:0]       cls;
    logic [TAG_W-1:0] tag;
    logic [RW-1:0]    dst;
    logic [RW-1:0]    s0;
    logic [RW-1:0]    s1;
    logic [1:0]       srcuse;
    logic [CNT_W-1:0] cnt;
  } desc_t;

  desc_t            fe_q, de_q, in_d;
  logic [1:0]       ex_cls;
  logic [RW-1:0]    ex_dst, m1_dst, m2_dst;
  logic [CNT_W-1:0] ex_left;
  logic             m1_ld, m2_ld;
  logic [NREG-1:0]  pend;

  logic de_hz, ex_mem, ex_done, ex_go, ex_free, de_go, fe_go, m1_go, acc;

  assign in_d    = '{cls: in_class, tag: in_tag, dst: in_dst, s0: in_src0,
                     s1: in_src1, srcuse: in_srcuse, cnt: in_cnt};
  assign fe_tag  = fe_q.tag;
  assign de_tag  = de_q.tag;

  assign de_hz   = de_v && ((de_q.srcuse[0] && pend[de_q.s0]) ||
                            (de_q.srcuse[1] && pend[de_q.s1]) ||
                            (de_q.cls != C_ST && pend[de_q.dst]));
  assign ex_mem  = (ex_cls == C_LD) || (ex_cls == C_ST);
  assign ex_done = ex_v && (ex_left == '0);
  assign m1_go   = m1_v && mem_rdy;
  assign ex_go   = ex_done && (!ex_mem || !m1_v || mem_rdy);
  assign ex_free = !ex_v || ex_go;
  assign de_go   = de_v && !de_hz && ex_free;
  assign in_ready = !de_v || de_go;
  assign fe_go   = fe_v && in_ready;
  assign acc     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      fe_v <= 1'b0; de_v <= 1'b0; ex_v <= 1'b0; m1_v <= 1'b0; m2_v <= 1'b0;
      wbi_we <= 1'b0; wbm_v <= 1'b0; wbm_we <= 1'b0;
      pend <= '0;
    end else begin
      if (acc)        fe_v <= 1'b1;
      else if (fe_go) fe_v <= 1'b0;

      if (fe_go)      de_v <= 1'b1;
      else if (de_go) de_v <= 1'b0;

      if (de_go)      ex_v <= 1'b1;
      else if (ex_go) ex_v <= 1'b0;
      else if (ex_v && ex_left != '0) ex_left <= ex_left - 1'b1;

      if (ex_go && ex_mem) m1_v <= 1'b1;
      else if (m1_go)      m1_v <= 1'b0;

      m2_v   <= m1_go;
      wbi_we <= ex_go && !ex_mem;
      wbm_v  <= m2_v;
      wbm_we <= m2_v && m2_ld;

      for (int r = 0; r < NREG; r++) begin
        if (de_go && de_q.cls == C_LD && de_q.dst == RW'(r)) pend[r] <= 1'b1;
        else if (wbm_we && wbm_reg == RW'(r))                pend[r] <= 1'b0;
      end
    end

    if (acc)   fe_q <= in_d;
    if (fe_go) de_q <= fe_q;
    if (de_go) begin
      ex_cls  <= de_q.cls;
      ex_tag  <= de_q.tag;
      ex_dst  <= de_q.dst;
      ex_left <= (de_q.cls == C_MUL && de_q.cnt != '0) ? de_q.cnt - 1'b1 : '0;
    end
    if (ex_go && ex_mem) begin
      m1_tag <= ex_tag; m1_dst <= ex_dst; m1_ld <= (ex_cls == C_LD);
    end
    if (m1_go) begin
      m2_tag <= m1_tag; m2_dst <= m1_dst; m2_ld <= m1_ld;
    end
    wbi_reg <= ex_dst;
    wbi_tag <= ex_tag;
    wbm_reg <= m2_dst;
    wbm_tag <= m2_tag;
  end

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    fe_v && !in_ready |=> fe_v && $stable(fe_tag)); // R9
  AST_DECODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    de_v && !in_ready |=> de_v && $stable(de_tag)); // R9
  AST_MEM_WAIT: assert property (@(posedge clk) disable iff (rst)
    m1_v && !mem_rdy |=> m1_v && $stable(m1_tag)); // R3
  AST_MEM2_DRAIN: assert property (@(posedge clk) disable iff (rst)
    m2_v |=> wbm_v && wbm_tag == $past(m2_tag)); // R2
  AST_MULTI_HOLD: assert property (@(posedge clk) disable iff (rst)
    ex_v && ex_left != '0 |=> ex_v && $stable(ex_tag)); // R5
  AST_LOAD_PENDING: assert property (@(posedge clk) disable iff (rst)
    wbm_we |-> pend[wbm_reg]); // R6
  AST_WB_PORTS_APART: assert property (@(posedge clk) disable iff (rst)
    wbi_we && wbm_v |-> wbi_tag != wbm_tag); // R7

endmodule

// File: tb/inorder_hazard_ctl_bench.sv
module inorder_hazard_ctl_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, mem_rdy = 1'b1;
  logic [1:0] in_class = 2'd0, in_srcuse = 2'd0;
  logic [3:0] in_tag = '0, in_dst = '0, in_src0 = '0, in_src1 = '0, in_cnt = '0;
  logic in_ready, fe_v, de_v, ex_v, m1_v, m2_v, wbi_we, wbm_v, wbm_we;
  logic [3:0] fe_tag, de_tag, ex_tag, m1_tag, m2_tag, wbi_reg, wbi_tag, wbm_reg, wbm_tag;

  inorder_hazard_ctl u_inorder_hazard_ctl (
    .clk, .rst, .in_valid, .in_ready, .in_class, .in_tag, .in_dst, .in_src0,
    .in_src1, .in_srcuse, .in_cnt, .mem_rdy, .fe_v, .fe_tag, .de_v, .de_tag,
    .ex_v, .ex_tag, .m1_v, .m1_tag, .m2_v, .m2_tag, .wbi_we, .wbi_reg, .wbi_tag,
    .wbm_v, .wbm_we, .wbm_reg, .wbm_tag);

  always #2 clk = ~clk;

  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int acc_c[16], wbi_c[16], wbm_c[16], wbm_w[16], wbm_r[16];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && wbi_we) wbi_c[wbi_tag] = cyc;
    if (!rst && wbm_v) begin
      wbm_c[wbm_tag] = cyc; wbm_w[wbm_tag] = wbm_we; wbm_r[wbm_tag] = wbm_reg;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear();
    for (int i = 0; i < 16; i++) begin
      acc_c[i] = -1; wbi_c[i] = -1; wbm_c[i] = -1; wbm_w[i] = -1; wbm_r[i] = -1;
    end
  endtask

  task automatic issue(input logic [1:0] cls, input int tag, input int dst,
                       input int s0, input int s1, input logic [1:0] use_, input int cnt);
    in_valid = 1'b1; in_class = cls; in_tag = 4'(tag); in_dst = 4'(dst);
    in_src0 = 4'(s0); in_src1 = 4'(s1); in_srcuse = use_; in_cnt = 4'(cnt);
    while (!in_ready) @(negedge clk);
    acc_c[tag] = cyc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!fe_v && !de_v && !ex_v && !m1_v && !m2_v && !wbi_we && !wbm_v, "R10 empty", 1, 0);
    chk(in_ready, "R10 ready", in_ready, 1);
    clear();
    issue(2'd1, 3, 6, 0, 0, 2'b00, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!fe_v && !de_v && !ex_v && !m1_v && !m2_v, "R10 flush", ex_v, 0);
    chk(in_ready, "R10 ready after flush", in_ready, 1);
    drain();
    chk(wbm_c[3] == -1, "R10 no writeback", wbm_c[3], -1);
    issue(2'd0, 4, 6, 6, 0, 2'b01, 0);
    drain();
    chk(wbi_c[4] == acc_c[4] + 4, "R10 pending cleared", wbi_c[4], acc_c[4] + 4);
  endtask

  task automatic t_stream();
    clear();
    for (int t = 1; t <= 4; t++) issue(2'd0, t, t, 0, 0, 2'b00, 0);
    drain();
    for (int t = 1; t <= 4; t++) begin
      chk(acc_c[t] == acc_c[1] + t - 1, "R1 one per cycle", acc_c[t], acc_c[1] + t - 1);
      chk(wbi_c[t] == acc_c[t] + 4, "R1 int latency", wbi_c[t], acc_c[t] + 4);
    end
  endtask

  task automatic t_ooo();
    clear();
    issue(2'd1, 5, 9, 15, 0, 2'b01, 0);
    issue(2'd0, 6, 10, 1, 2, 2'b11, 0);
    drain();
    chk(wbm_c[5] == acc_c[5] + 6 && wbm_w[5] == 1 && wbm_r[5] == 9, "R2 load latency", wbm_c[5], acc_c[5] + 6);
    chk(wbi_c[6] == acc_c[6] + 4, "R4 int latency", wbi_c[6], acc_c[6] + 4);
    chk(wbi_c[6] < wbm_c[5], "R4 int before load", wbi_c[6], wbm_c[5] - 1);
    clear();
    issue(2'd2, 7, 5, 3, 0, 2'b01, 0);
    issue(2'd0, 8, 11, 5, 0, 2'b01, 0);
    drain();
    chk(wbm_c[7] == acc_c[7] + 6, "R8 store slot", wbm_c[7], acc_c[7] + 6);
    chk(wbm_w[7] == 0, "R8 store no write", wbm_w[7], 0);
    chk(wbi_c[8] == acc_c[8] + 4, "R8 no pending after store", wbi_c[8], acc_c[8] + 4);
  endtask

  task automatic t_memwait();
    int m;
    clear();
    issue(2'd1, 9, 12, 0, 0, 2'b00, 0);
    while (!(m1_v && m1_tag == 4'd9)) @(negedge clk);
    m = cyc;
    chk(m == acc_c[9] + 4, "R2 memory-1 entry", m, acc_c[9] + 4);
    mem_rdy = 1'b0;
    @(negedge clk);
    chk(m1_v && m1_tag == 4'd9 && !m2_v, "R3 hold in memory-1", m1_tag, 9);
    @(negedge clk);
    mem_rdy = 1'b1;
    @(negedge clk);
    chk(m2_v && m2_tag == 4'd9, "R3 enter memory-2", m2_v, 1);
    drain();
    chk(wbm_c[9] == acc_c[9] + 8, "R3 stalled load latency", wbm_c[9], acc_c[9] + 8);
  endtask

  task automatic t_multi();
    clear();
    issue(2'd3, 10, 13, 1, 2, 2'b11, 3);
    issue(2'd0, 11, 14, 0, 0, 2'b00, 0);
    drain();
    chk(wbi_c[10] == acc_c[10] + 6, "R5 multi latency", wbi_c[10], acc_c[10] + 6);
    chk(wbi_c[11] == acc_c[10] + 7, "R5 follower waits", wbi_c[11], acc_c[10] + 7);
    issue(2'd3, 12, 13, 0, 0, 2'b00, 0);
    drain();
    chk(wbi_c[12] == acc_c[12] + 4, "R5 count zero", wbi_c[12], acc_c[12] + 4);
  endtask

  task automatic t_hazard();
    clear();
    issue(2'd1, 13, 7, 0, 0, 2'b00, 0);
    issue(2'd0, 14, 1, 7, 0, 2'b01, 0);
    @(negedge clk); @(negedge clk);
    chk(!in_ready && de_v && de_tag == 4'd14, "R9 decode stall", in_ready, 0);
    drain();
    chk(wbi_c[14] == wbm_c[13] + 3, "R6 read after load", wbi_c[14], wbm_c[13] + 3);
    clear();
    issue(2'd1, 15, 8, 0, 0, 2'b00, 0);
    issue(2'd0, 0, 8, 0, 0, 2'b00, 0);
    drain();
    chk(wbi_c[0] == wbm_c[15] + 3, "R6 write after load", wbi_c[0], wbm_c[15] + 3);
  endtask

  task automatic t_collide();
    clear();
    issue(2'd1, 1, 3, 0, 0, 2'b00, 0);
    @(negedge clk);
    issue(2'd0, 2, 4, 0, 0, 2'b00, 0);
    drain();
    chk(wbm_c[1] == acc_c[1] + 6 && wbm_w[1] == 1, "R7 load port", wbm_c[1], acc_c[1] + 6);
    chk(wbi_c[2] == wbm_c[1], "R7 same cycle", wbi_c[2], wbm_c[1]);
  endtask

  initial begin
    clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stream();
    t_ooo();
    t_memwait();
    t_multi();
    t_hazard();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule